// File: doc/BRIEF.md
# Interrupt Controller Setup and Run Word Sequencer

This block is the programming front end of an interrupt controller. A host writes bytes over a small synchronous bus made of an 8-bit data input, one address bit and an active-low write strobe. The block works out which internal word each write belongs to. It holds the result as decoded configuration flags and as the contents of three run-time words. A ready flag tells the rest of the controller that setup is finished and that interrupts may be accepted.

Setup is a fixed chain of words. It always begins with a first word. `MID_WORDS` mandatory words follow it. A closing option word comes last, but only when the first word asked for it. Once ready is high, the three run words can be written in any order and as often as the host likes. The option word's bits become the processor-mode, automatic end-of-interrupt, buffered, special nested and master/slave flags. Prioritization, the request and in-service registers, cascading and the acknowledge cycle live in other blocks.

Top module: `pic_cw_sequencer`

## Requirements
- R1: After `rst_ni` is released, `ready_o`, every flag output, `mask_o`, `op2_o` and `op3_o` are 0, and the sequencer waits for a first word.
- R2: A first word is any write whose strobe falls with `addr_i`=0 and `din_i[4]`=1. At any time it restarts setup, and `ready_o` is 0 from the clock edge that sees the strobe fall.
- R3: A first word clears all option-word flags to 0 on that same edge.
- R4: After the first word come `MID_WORDS` further words, whatever their address bit. The option word follows only if bit 0 of the first word was 1. `ready_o` rises on the clock edge after the strobe returns high at the end of the last word of the chain.
- R5: While the strobe is low, the data is captured on every rising clock edge, so the byte held on the final low cycle is the one kept. The word the write is aimed at is chosen on the edge where the strobe falls.
- R6: A write moves on to the next word only when its own strobe falls. After the last setup word, a further write with `addr_i`=1 goes to the run words and leaves every option flag unchanged.
- R7: In the option word, bit 0 drives `single_byte_o`, bit 1 drives `auto_eoi_o`, bit 3 drives `buffered_o` and bit 4 drives `special_nested_o`.
- R8: Option bit 2 drives `slave_o` only while option bit 3 is 1. Otherwise `slave_o` is 0, which means master.
- R9: Option bits 7:5 have no effect on any output.
- R10: Once `ready_o` is high, a write with `addr_i`=1 loads `mask_o`. A write with `addr_i`=0, `din_i[4]`=0 and `din_i[3]`=0 loads `op2_o`. A write with `addr_i`=0, `din_i[4]`=0 and `din_i[3]`=1 loads `op3_o`. These writes may come in any order.
- R11: Writes made before any first word change no output.
- R12: While `ready_o` stays high, the flag outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write strobe, active low, synchronous to clk_i |
| addr_i | input | 1 | Address bit of the write |
| din_i | input | DATA_W | Write data |
| ready_o | output | 1 | Setup complete |
| single_byte_o | output | 1 | 1: single-byte acknowledge sequence, 0: three-byte sequence |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt enabled |
| slave_o | output | 1 | 1: slave, 0: master (meaningful only in buffered mode) |
| buffered_o | output | 1 | Buffered mode |
| special_nested_o | output | 1 | Special fully nested mode |
| mask_o | output | DATA_W | Run word written with addr_i=1 |
| op2_o | output | DATA_W | Run word written with addr_i=0, din_i[3]=0 |
| op3_o | output | DATA_W | Run word written with addr_i=0, din_i[3]=1 |

## Verification
The bench builds the block with `DATA_W`=8 and `MID_WORDS`=2. This gives the usual four-word chain and makes both the long setup path (option word present) and the short one (option word skipped) reachable, as well as restarts in the middle of a chain. Multi-cycle strobes with data that changes mid-write separate the byte used to pick the target from the byte that is finally stored. With 8-bit data, the ignored option bits 7:5 can be driven high and shown to have no effect.

// File: rtl/pic_cw_pkg.sv
package pic_cw_pkg;
  // write decode bit positions (host-visible encoding)
  localparam int FIRST_MARK_BIT = 4;
  localparam int OP3_MARK_BIT   = 3;
  localparam int NEED_OPT_BIT   = 0;

  // option word fields
  localparam int CFG_W    = 5;
  localparam int CFG_SB   = 0;
  localparam int CFG_AEOI = 1;
  localparam int CFG_MS   = 2;
  localparam int CFG_BUF  = 3;
  localparam int CFG_SFN  = 4;

  localparam int NUM_OPS = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_OPT, PH_RUN} phase_e;
  typedef enum logic [2:0] {
    TGT_NONE, TGT_FIRST, TGT_MID, TGT_OPT, TGT_OP1, TGT_OP2, TGT_OP3
  } tgt_e;
endpackage

// File: rtl/pic_cw_strobe.sv
module pic_cw_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  output logic active_o,
  output logic fall_o,
  output logic rise_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  assign active_o = ~wr_ni;
  assign fall_o   = wr_q & ~wr_ni;
  assign rise_o   = ~wr_q & wr_ni;
endmodule

// File: rtl/pic_cw_seq.sv
module pic_cw_seq
  import pic_cw_pkg::*;
#(
  parameter int MID_WORDS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic fall_i,
  input  logic rise_i,
  input  logic addr_i,
  input  logic mark_first_i,
  input  logic mark_op3_i,
  input  logic need_opt_i,
  output tgt_e tgt_o,
  output logic restart_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(MID_WORDS + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MID_WORDS);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  tgt_e             tgt_q, tgt_d, op_tgt;
  logic             need_q, ready_q, restart, last_word;

  assign restart = fall_i & ~addr_i & mark_first_i;
  assign op_tgt  = addr_i ? TGT_OP1 : (mark_op3_i ? TGT_OP3 : TGT_OP2);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    if (restart) begin
      phase_d = PH_INIT;
      cnt_d   = '0;
      tgt_d   = TGT_FIRST;
    end else if (fall_i) begin
      unique case (phase_q)
        PH_IDLE: tgt_d = TGT_NONE;
        PH_INIT: begin
          if (cnt_q != CNT_LAST) begin
            cnt_d = cnt_q + 1'b1;
            tgt_d = TGT_MID;
          end else if (need_q) begin
            phase_d = PH_OPT;
            tgt_d   = TGT_OPT;
          end else begin
            phase_d = PH_RUN;
            tgt_d   = op_tgt;
          end
        end
        PH_OPT: begin
          phase_d = PH_RUN;
          tgt_d   = op_tgt;
        end
        default: tgt_d = op_tgt;
      endcase
    end
  end

  // last word of the chain is being closed by this strobe release
  assign last_word = (phase_q == PH_OPT) ||
                     (phase_q == PH_INIT && cnt_q == CNT_LAST && !need_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tgt_q   <= TGT_NONE;
      need_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
      if (active_i && tgt_d == TGT_FIRST) need_q <= need_opt_i;
      if (restart)                  ready_q <= 1'b0;
      else if (rise_i && last_word) ready_q <= 1'b1;
    end
  end

  assign tgt_o     = active_i ? tgt_d : TGT_NONE;
  assign restart_o = restart;
  assign ready_o   = ready_q;
endmodule

// File: rtl/pic_cw_regs.sv
module pic_cw_regs
  import pic_cw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  tgt_e              tgt_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              single_byte_o,
  output logic              auto_eoi_o,
  output logic              slave_o,
  output logic              buffered_o,
  output logic              special_nested_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] op2_o,
  output logic [DATA_W-1:0] op3_o
);
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] op_q [NUM_OPS];

  function automatic tgt_e op_sel(input int idx);
    case (idx)
      0:       return TGT_OP1;
      1:       return TGT_OP2;
      default: return TGT_OP3;
    endcase
  endfunction

  // bits above CFG_W are never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_q <= '0;
    else if (restart_i)         cfg_q <= '0;
    else if (tgt_i == TGT_OPT)  cfg_q <= din_i[CFG_W-1:0];
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 op_q[g] <= '0;
      else if (tgt_i == op_sel(g)) op_q[g] <= din_i;
    end
  end

  assign single_byte_o    = cfg_q[CFG_SB];
  assign auto_eoi_o       = cfg_q[CFG_AEOI];
  assign buffered_o       = cfg_q[CFG_BUF];
  assign special_nested_o = cfg_q[CFG_SFN];
  assign slave_o          = cfg_q[CFG_BUF] & cfg_q[CFG_MS];
  assign mask_o           = op_q[0];
  assign op2_o            = op_q[1];
  assign op3_o            = op_q[2];
endmodule

// File: rtl/pic_cw_sequencer.sv
module pic_cw_sequencer
  import pic_cw_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MID_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              ready_o,
  output logic              single_byte_o,
  output logic              auto_eoi_o,
  output logic              slave_o,
  output logic              buffered_o,
  output logic              special_nested_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] op2_o,
  output logic [DATA_W-1:0] op3_o
);
  logic active, fall, rise, restart;
  tgt_e tgt;

  pic_cw_strobe u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ni   (wr_ni),
    .active_o(active),
    .fall_o  (fall),
    .rise_o  (rise)
  );

  pic_cw_seq #(.MID_WORDS(MID_WORDS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .fall_i      (fall),
    .rise_i      (rise),
    .addr_i      (addr_i),
    .mark_first_i(din_i[FIRST_MARK_BIT]),
    .mark_op3_i  (din_i[OP3_MARK_BIT]),
    .need_opt_i  (din_i[NEED_OPT_BIT]),
    .tgt_o       (tgt),
    .restart_o   (restart),
    .ready_o     (ready_o)
  );

  pic_cw_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .restart_i       (restart),
    .tgt_i           (tgt),
    .din_i           (din_i),
    .single_byte_o   (single_byte_o),
    .auto_eoi_o      (auto_eoi_o),
    .slave_o         (slave_o),
    .buffered_o      (buffered_o),
    .special_nested_o(special_nested_o),
    .mask_o          (mask_o),
    .op2_o           (op2_o),
    .op3_o           (op3_o)
  );
endmodule

// File: rtl/pic_cw_sequencer_chk.sv
module pic_cw_sequencer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_ni,
  input logic              addr_i,
  input logic              mark_first_i,
  input logic              ready_o,
  input logic              single_byte_o,
  input logic              auto_eoi_o,
  input logic              slave_o,
  input logic              buffered_o,
  input logic              special_nested_o,
  input logic [DATA_W-1:0] mask_o,
  input logic [DATA_W-1:0] op2_o,
  input logic [DATA_W-1:0] op3_o
);
  logic [4:0] flags;
  assign flags = {special_nested_o, buffered_o, slave_o, auto_eoi_o, single_byte_o};

  p_restart_clears_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && $past(wr_ni) && !addr_i && mark_first_i) |=> !ready_o);

  p_restart_clears_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && $past(wr_ni) && !addr_i && mark_first_i) |=> (flags == 5'b0));

  p_ready_after_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(wr_ni) && !$past(wr_ni, 2)));

  p_run_words_need_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mask_o) || !$stable(op2_o) || !$stable(op3_o)) |-> $past(ready_o));

  p_flags_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(flags));
endmodule

bind pic_cw_sequencer pic_cw_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_ni           (wr_ni),
  .addr_i          (addr_i),
  .mark_first_i    (din_i[4]),
  .ready_o         (ready_o),
  .single_byte_o   (single_byte_o),
  .auto_eoi_o      (auto_eoi_o),
  .slave_o         (slave_o),
  .buffered_o      (buffered_o),
  .special_nested_o(special_nested_o),
  .mask_o          (mask_o),
  .op2_o           (op2_o),
  .op3_o           (op3_o)
);

// File: tb/pic_cw_sequencer_bench.sv
`timescale 1ns/1ps
module pic_cw_sequencer_bench;
  localparam int DATA_W = 8;
  localparam int MID    = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_ni = 1'b1;
  logic addr = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic ready, sb, aeoi, slave, buff, sfn;
  logic [DATA_W-1:0] mask, op2, op3;

  always #5 clk = ~clk;

  pic_cw_sequencer #(.DATA_W(DATA_W), .MID_WORDS(MID)) u_pic_cw_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .wr_ni(wr_ni), .addr_i(addr), .din_i(din),
    .ready_o(ready), .single_byte_o(sb), .auto_eoi_o(aeoi), .slave_o(slave),
    .buffered_o(buff), .special_nested_o(sfn),
    .mask_o(mask), .op2_o(op2), .op3_o(op3)
  );

  typedef struct {
    logic       rdy;
    logic [4:0] flg;  // {sfn, buf, slave, aeoi, sb}
    logic [7:0] msk, o2, o3;
    string      tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state, from the requirements
  int m_phase = 0;  // 0 idle, 1 chain, 2 option, 3 run
  int m_cnt   = 0;
  bit m_need  = 0;
  bit m_ready = 0;
  logic [4:0] m_cfg = '0;
  logic [7:0] m_mask = '0, m_op2 = '0, m_op3 = '0;

  task automatic push_exp(input string tag);
    exp_t e;
    e.rdy = m_ready;
    e.flg = {m_cfg[4], m_cfg[3], m_cfg[3] & m_cfg[2], m_cfg[1], m_cfg[0]};
    e.msk = m_mask; e.o2 = m_op2; e.o3 = m_op3;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model_run(input bit a, input logic [7:0] df, input logic [7:0] dl);
    if (a)          m_mask = dl;
    else if (df[3]) m_op3  = dl;
    else            m_op2  = dl;
  endtask

  task automatic model(input bit a, input logic [7:0] df, input logic [7:0] dl);
    if (!a && df[4]) begin
      m_phase = 1; m_cnt = 0; m_need = dl[0]; m_ready = 0; m_cfg = '0;
    end else begin
      case (m_phase)
        1: begin
          if (m_cnt < MID) m_cnt++;
          else if (m_need) begin m_phase = 2; m_cfg = dl[4:0]; end
          else begin m_phase = 3; model_run(a, df, dl); end
        end
        2: begin m_phase = 3; model_run(a, df, dl); end
        3: model_run(a, df, dl);
        default: ;
      endcase
    end
    if ((m_phase == 1 && m_cnt == MID && !m_need) || m_phase == 2) m_ready = 1;
  endtask

  // driver: byte df on the falling cycle, dl on the remaining low cycles
  task automatic put_word(input bit a, input logic [7:0] df, input logic [7:0] dl,
                          input int hold, input string tag);
    @(negedge clk);
    addr = a; din = df; wr_ni = 1'b0;
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      din = dl;
    end
    @(negedge clk);
    wr_ni = 1'b1;
    repeat (2) @(negedge clk);
    model(a, df, (hold > 1) ? dl : df);
    push_exp(tag);
  endtask

  task automatic wr(input bit a, input logic [7:0] d, input string tag);
    put_word(a, d, d, 1, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (ready !== e.rdy || {sfn, buff, slave, aeoi, sb} !== e.flg ||
            mask !== e.msk || op2 !== e.o2 || op3 !== e.o3) begin
          errors++;
          $display("FAIL %s: got rdy=%b flg=%b mask=%h op2=%h op3=%h exp rdy=%b flg=%b mask=%h op2=%h op3=%h",
                   e.tag, ready, {sfn, buff, slave, aeoi, sb}, mask, op2, op3,
                   e.rdy, e.flg, e.msk, e.o2, e.o3);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    push_exp("R1 reset state");

    wr(1'b1, 8'hFF, "R11 run write before setup ignored");
    wr(1'b0, 8'h08, "R11 op3-coded write before setup ignored");

    // long chain with option word
    wr(1'b0, 8'h13, "R2 first word drops ready");
    wr(1'b1, 8'h20, "R4 mid word 1 keeps ready low");
    wr(1'b1, 8'h00, "R4 mid word 2 keeps ready low when option pending");
    wr(1'b1, 8'hFF, "R4 R7 R9 option word sets all flags, upper bits ignored");

    wr(1'b1, 8'h5A, "R6 R10 after setup addr 1 loads mask not flags");
    wr(1'b0, 8'h0B, "R10 op3 coded write");
    wr(1'b0, 8'h20, "R10 op2 coded write");
    wr(1'b1, 8'hC3, "R10 R12 mask again, flags frozen");
    put_word(1'b0, 8'h08, 8'h41, 3, "R5 target fixed at fall, last byte kept");

    // short chain, option skipped
    wr(1'b0, 8'h10, "R2 R3 restart clears ready and flags");
    wr(1'b1, 8'h44, "R4 short chain mid 1");
    wr(1'b1, 8'h01, "R4 short chain completes without option word");
    wr(1'b1, 8'h07, "R6 next addr 1 write lands in mask");

    // slave bit without buffered
    wr(1'b0, 8'h11, "R2 restart toward option word");
    wr(1'b1, 8'h00, "R4 mid 1");
    wr(1'b1, 8'h00, "R4 mid 2");
    wr(1'b1, 8'h04, "R8 slave bit ignored without buffered");

    // restart in the middle of a chain, multi-cycle option write
    wr(1'b0, 8'h11, "R2 restart");
    wr(1'b1, 8'h00, "R4 mid 1");
    wr(1'b0, 8'h11, "R2 restart mid chain");
    wr(1'b1, 8'h00, "R4 mid 1 after restart");
    wr(1'b1, 8'h00, "R4 mid 2 after restart");
    put_word(1'b1, 8'h00, 8'hEC, 4, "R5 R8 R9 option last byte, slave with buffered");
    wr(1'b0, 8'h08, "R10 R12 op3 write, flags frozen");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule